// File: doc/BRIEF.md
# Scratchpad Register Array and Pointer Unit

This block holds the sixteen 16-bit scratchpad registers of a small 8-bit processor. It also holds the 4-bit selectors that pick among them: the program-counter selector P, the data-pointer selector X and the operand nibble N. Alongside these it keeps the opcode high nibble I, the 8-bit context save register T and the interrupt enable flag. Each cycle a command from the sequencer picks one register and presents it as the 16-bit memory address. The command may also write that register back, incremented, decremented or with one byte replaced.

The register roles are fixed by the command. The fetch command uses R(P) and the operand commands use R(X). The register commands use R(N) and DMA uses R0. Interrupt entry packs X and P into T, then points X at R2 (the interrupt stack) and P at R1 (the interrupt program counter). Return and disable reload X and P from a memory byte and step R(X). Memory and the ALU sit outside the block.

Top module: `scratch_ptr_unit`

## Requirements
- R1: While rst_ni is low, and until the first command after it rises, P, X, N and I read 0 and IE reads 1. All sixteen registers are cleared to 0000.
- R2: FETCH (code 1) drives addr_o with R(P). At the clock edge R(P) gains one, I takes data_i[7:4] and N takes data_i[3:0].
- R3: DMA (code 2) drives addr_o with R0, and R0 gains one at the edge. After clear, one DMA followed by FETCH fetches from address 0001.
- R4: INT (code 3) copies {X,P} into T with X in bits 7:4. It then sets X to 2, P to 1 and IE to 0.
- R5: RN_INC (code 4) and RN_DEC (code 5) drive addr_o with R(N) and add or subtract one at the edge, wrapping modulo 65536.
- R6: PUT_LO (code 8) and PUT_HI (code 9) write data_i into the low or high byte of R(N) and keep the other byte. GET_LO (code 10) and GET_HI (code 11) drive that byte of R(N) on byte_o.
- R7: SET_P (code 12) copies N into P. SET_X (code 13) copies N into X.
- R8: RET (code 14) and DIS (code 15) drive addr_o with R(X) and step that register by one. They load X from data_i[7:4] and P from data_i[3:0]. RET sets IE to 1 and DIS sets it to 0.
- R9: SAVE_T (code 16) drives addr_o with R(X) and byte_o with T. byte_o is 00 for every code other than 10, 11 and 16.
- R10: RX_READ (code 6) drives addr_o with R(X) and changes nothing. RX_INC (code 7) drives addr_o with R(X) and steps it by one.
- R11: IDLE (code 0) and the unassigned codes 17 to 31 change no register or selector and drive addr_o with R(P). No edge changes more than one scratchpad register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low clear |
| cmd_i | input | 5 | Command code for this cycle |
| data_i | input | 8 | Byte for opcode, byte writes and X/P reload |
| addr_o | output | 16 | Register selected by the command, used as memory address |
| byte_o | output | 8 | Register byte or T for the read commands, else 00 |
| p_o | output | 4 | Program-counter selector P |
| x_o | output | 4 | Data-pointer selector X |
| n_o | output | 4 | Operand nibble N |
| i_o | output | 4 | Opcode high nibble I |
| ie_o | output | 1 | Interrupt enable flag |

## Verification
A register that holds a wrong value, or that was written by a command aimed elsewhere, shows up on addr_o the next time any command selects it. Byte reads also bring it to byte_o in the same cycle. A wrong selector shows up on its own port one cycle after the command that set it. It also shows up on addr_o in the next cycle that uses that selector. Every register is read back after byte writes, stepping sweeps and an unassigned command, so a stray write is caught within one readback pass.

// File: rtl/spu_pkg.sv
package spu_pkg;
  localparam int unsigned CMD_W = 5;

  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE    = 5'd0,
    CMD_FETCH   = 5'd1,
    CMD_DMA     = 5'd2,
    CMD_INT     = 5'd3,
    CMD_RN_INC  = 5'd4,
    CMD_RN_DEC  = 5'd5,
    CMD_RX_READ = 5'd6,
    CMD_RX_INC  = 5'd7,
    CMD_PUT_LO  = 5'd8,
    CMD_PUT_HI  = 5'd9,
    CMD_GET_LO  = 5'd10,
    CMD_GET_HI  = 5'd11,
    CMD_SET_P   = 5'd12,
    CMD_SET_X   = 5'd13,
    CMD_RET     = 5'd14,
    CMD_DIS     = 5'd15,
    CMD_SAVE_T  = 5'd16
  } spu_cmd_e;
endpackage

// File: rtl/spu_reg_bank.sv
module spu_reg_bank #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [W-1:0]     rdata_o
);
  localparam int unsigned NUM = 1 << IDX_W;

  logic [NUM-1:0][W-1:0] q;

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q_r <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))     q_r <= wdata_i;
    end
    assign q[g] = q_r;
  end

  assign rdata_o = q[ridx_i];
endmodule

// File: rtl/spu_incdec.sv
module spu_incdec #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] ONE = W'(1);
  // wraps modulo 2**W
  assign val_o = dec_i ? (val_i - ONE) : (val_i + ONE);
endmodule

// File: rtl/spu_decode.sv
module spu_decode
  import spu_pkg::*;
#(
  parameter int unsigned       SEL_W   = 4,
  parameter logic [SEL_W-1:0]  DMA_SEL = '0
) (
  input  spu_cmd_e         cmd_i,
  input  logic [SEL_W-1:0] p_i,
  input  logic [SEL_W-1:0] x_i,
  input  logic [SEL_W-1:0] n_i,
  output logic [SEL_W-1:0] idx_o,
  output logic             we_o,
  output logic             dec_o
);
  always_comb begin
    idx_o = p_i;
    we_o  = 1'b0;
    dec_o = 1'b0;
    unique case (cmd_i)
      CMD_FETCH:                  we_o = 1'b1;
      CMD_DMA: begin
        idx_o = DMA_SEL;
        we_o  = 1'b1;
      end
      CMD_RN_INC, CMD_PUT_LO, CMD_PUT_HI: begin
        idx_o = n_i;
        we_o  = 1'b1;
      end
      CMD_RN_DEC: begin
        idx_o = n_i;
        we_o  = 1'b1;
        dec_o = 1'b1;
      end
      CMD_GET_LO, CMD_GET_HI:     idx_o = n_i;
      CMD_RX_INC, CMD_RET, CMD_DIS: begin
        idx_o = x_i;
        we_o  = 1'b1;
      end
      CMD_RX_READ, CMD_SAVE_T:    idx_o = x_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/scratch_ptr_unit.sv
module scratch_ptr_unit
  import spu_pkg::*;
#(
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned DMA_IDX    = 0,
  parameter int unsigned INT_PC_IDX = 1,
  parameter int unsigned INT_SP_IDX = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [2*SEL_W-1:0]   data_i,
  output logic [4*SEL_W-1:0]   addr_o,
  output logic [2*SEL_W-1:0]   byte_o,
  output logic [SEL_W-1:0]     p_o,
  output logic [SEL_W-1:0]     x_o,
  output logic [SEL_W-1:0]     n_o,
  output logic [SEL_W-1:0]     i_o,
  output logic                 ie_o
);
  localparam int unsigned BYTE_W = 2 * SEL_W;
  localparam int unsigned REG_W  = 2 * BYTE_W;
  localparam logic [SEL_W-1:0] DMA_SEL = SEL_W'(DMA_IDX);
  localparam logic [SEL_W-1:0] PC_SEL  = SEL_W'(INT_PC_IDX);
  localparam logic [SEL_W-1:0] SP_SEL  = SEL_W'(INT_SP_IDX);

  spu_cmd_e cmd;
  assign cmd = spu_cmd_e'(cmd_i);

  logic [SEL_W-1:0]  p_q, x_q, n_q, i_q;
  logic [BYTE_W-1:0] t_q;
  logic              ie_q;

  logic [SEL_W-1:0] sel_idx;
  logic             sel_we, sel_dec;
  logic [REG_W-1:0] sel_val, step_val, wdata;

  spu_decode #(.SEL_W(SEL_W), .DMA_SEL(DMA_SEL)) u_decode (
    .cmd_i (cmd),
    .p_i   (p_q),
    .x_i   (x_q),
    .n_i   (n_q),
    .idx_o (sel_idx),
    .we_o  (sel_we),
    .dec_o (sel_dec)
  );

  spu_reg_bank #(.IDX_W(SEL_W), .W(REG_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sel_we),
    .widx_i  (sel_idx),
    .wdata_i (wdata),
    .ridx_i  (sel_idx),
    .rdata_o (sel_val)
  );

  spu_incdec #(.W(REG_W)) u_step (
    .val_i (sel_val),
    .dec_i (sel_dec),
    .val_o (step_val)
  );

  always_comb begin
    unique case (cmd)
      CMD_PUT_LO: wdata = {sel_val[REG_W-1:BYTE_W], data_i};
      CMD_PUT_HI: wdata = {data_i, sel_val[BYTE_W-1:0]};
      default:    wdata = step_val;
    endcase
  end

  always_comb begin
    unique case (cmd)
      CMD_GET_LO: byte_o = sel_val[BYTE_W-1:0];
      CMD_GET_HI: byte_o = sel_val[REG_W-1:BYTE_W];
      CMD_SAVE_T: byte_o = t_q;
      default:    byte_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q  <= '0;
      x_q  <= '0;
      n_q  <= '0;
      i_q  <= '0;
      t_q  <= '0;
      ie_q <= 1'b1;
    end else begin
      unique case (cmd)
        CMD_FETCH: begin
          i_q <= data_i[BYTE_W-1:SEL_W];
          n_q <= data_i[SEL_W-1:0];
        end
        CMD_INT: begin
          t_q  <= {x_q, p_q};
          x_q  <= SP_SEL;
          p_q  <= PC_SEL;
          ie_q <= 1'b0;
        end
        CMD_SET_P: p_q <= n_q;
        CMD_SET_X: x_q <= n_q;
        CMD_RET, CMD_DIS: begin
          x_q  <= data_i[BYTE_W-1:SEL_W];
          p_q  <= data_i[SEL_W-1:0];
          ie_q <= (cmd == CMD_RET);
        end
        default: ;
      endcase
    end
  end

  assign addr_o = sel_val;
  assign p_o    = p_q;
  assign x_o    = x_q;
  assign n_o    = n_q;
  assign i_o    = i_q;
  assign ie_o   = ie_q;
endmodule

// File: rtl/spu_checker.sv
module spu_checker
  import spu_pkg::*;
#(
  parameter int unsigned SEL_W      = 4,
  parameter int unsigned INT_PC_IDX = 1,
  parameter int unsigned INT_SP_IDX = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CMD_W-1:0]   cmd_i,
  input logic [2*SEL_W-1:0] data_i,
  input logic [4*SEL_W-1:0] addr_o,
  input logic [2*SEL_W-1:0] byte_o,
  input logic [SEL_W-1:0]   p_o,
  input logic [SEL_W-1:0]   x_o,
  input logic [SEL_W-1:0]   n_o,
  input logic [SEL_W-1:0]   i_o,
  input logic               ie_o
);
  localparam int unsigned REG_W = 4 * SEL_W;
  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_clear_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (p_o == '0 && x_o == '0 && n_o == '0 && ie_o));

  assert_fetch_nibbles_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_FETCH |=> (i_o == $past(data_i[2*SEL_W-1:SEL_W]) && n_o == $past(data_i[SEL_W-1:0])));

  assert_fetch_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cmd_i == CMD_FETCH && $past(cmd_i) == CMD_FETCH) |-> addr_o == $past(addr_o) + ONE);

  assert_dma_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cmd_i == CMD_DMA && $past(cmd_i) == CMD_DMA) |-> addr_o == $past(addr_o) + ONE);

  assert_int_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_INT |=> (p_o == SEL_W'(INT_PC_IDX) && x_o == SEL_W'(INT_SP_IDX) && !ie_o));

  assert_rn_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cmd_i == CMD_RN_DEC && $past(cmd_i) == CMD_RN_DEC) |-> addr_o == $past(addr_o) - ONE);

  assert_set_p_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_SET_P |=> p_o == $past(n_o));

  assert_set_x_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_SET_X |=> x_o == $past(n_o));

  assert_ret_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_RET |=> ({x_o, p_o} == $past(data_i) && ie_o));

  assert_dis_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_DIS |=> ({x_o, p_o} == $past(data_i) && !ie_o));

  assert_save_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cmd_i == CMD_SAVE_T && $past(cmd_i) == CMD_INT) |-> byte_o == {$past(x_o), $past(p_o)});

  assert_byte_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_GET_LO && cmd_i != CMD_GET_HI && cmd_i != CMD_SAVE_T) |-> byte_o == '0);

  assert_rx_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cmd_i == CMD_RX_READ && $past(cmd_i) == CMD_RX_INC) |-> addr_o == $past(addr_o) + ONE);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_IDLE |=> ($stable(p_o) && $stable(x_o) && $stable(n_o) && $stable(i_o) && $stable(ie_o)));
endmodule

bind scratch_ptr_unit spu_checker #(
  .SEL_W(SEL_W), .INT_PC_IDX(INT_PC_IDX), .INT_SP_IDX(INT_SP_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .data_i(data_i),
  .addr_o(addr_o), .byte_o(byte_o), .p_o(p_o), .x_o(x_o),
  .n_o(n_o), .i_o(i_o), .ie_o(ie_o)
);

// File: tb/scratch_ptr_unit_tb.sv
`timescale 1ns/1ps
module scratch_ptr_unit_tb;
  import spu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  cmd_i = 5'd0;
  logic [7:0]  data_i = 8'd0;
  logic [15:0] addr_o;
  logic [7:0]  byte_o;
  logic [3:0]  p_o, x_o, n_o, i_o;
  logic        ie_o;

  always #4 clk = ~clk;

  scratch_ptr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .data_i(data_i),
    .addr_o(addr_o), .byte_o(byte_o), .p_o(p_o), .x_o(x_o),
    .n_o(n_o), .i_o(i_o), .ie_o(ie_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected state, built from the requirements
  logic [15:0] m_r [16];
  logic [3:0]  m_p, m_x, m_n, m_i;
  logic [7:0]  m_t;
  logic        m_ie;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                     input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] c, input logic [7:0] d, input string tag);
    logic [3:0] idx;
    logic [7:0] eb;
    @(negedge clk);
    cmd_i  = c;
    data_i = d;
    #1;
    case (c)
      CMD_DMA: idx = 4'd0;
      CMD_RN_INC, CMD_RN_DEC, CMD_PUT_LO, CMD_PUT_HI, CMD_GET_LO, CMD_GET_HI: idx = m_n;
      CMD_RX_READ, CMD_RX_INC, CMD_RET, CMD_DIS, CMD_SAVE_T: idx = m_x;
      default: idx = m_p;
    endcase
    case (c)
      CMD_GET_LO: eb = m_r[m_n][7:0];
      CMD_GET_HI: eb = m_r[m_n][15:8];
      CMD_SAVE_T: eb = m_t;
      default:    eb = 8'h00;
    endcase
    chk(addr_o, m_r[idx], tag, "addr_o");
    chk({8'h00, byte_o}, {8'h00, eb}, tag, "byte_o");
    @(posedge clk);
    #1;
    case (c)
      CMD_FETCH:  begin m_r[m_p] = m_r[m_p] + 16'd1; m_i = d[7:4]; m_n = d[3:0]; end
      CMD_DMA:    m_r[0] = m_r[0] + 16'd1;
      CMD_INT:    begin m_t = {m_x, m_p}; m_x = 4'd2; m_p = 4'd1; m_ie = 1'b0; end
      CMD_RN_INC: m_r[m_n] = m_r[m_n] + 16'd1;
      CMD_RN_DEC: m_r[m_n] = m_r[m_n] - 16'd1;
      CMD_RX_INC: m_r[m_x] = m_r[m_x] + 16'd1;
      CMD_PUT_LO: m_r[m_n][7:0]  = d;
      CMD_PUT_HI: m_r[m_n][15:8] = d;
      CMD_SET_P:  m_p = m_n;
      CMD_SET_X:  m_x = m_n;
      CMD_RET, CMD_DIS: begin
        m_r[m_x] = m_r[m_x] + 16'd1;
        m_x = d[7:4];
        m_p = d[3:0];
        m_ie = (c == CMD_RET);
      end
      default: ;
    endcase
    chk({12'h0, p_o}, {12'h0, m_p}, tag, "p_o");
    chk({12'h0, x_o}, {12'h0, m_x}, tag, "x_o");
    chk({12'h0, n_o}, {12'h0, m_n}, tag, "n_o");
    chk({12'h0, i_o}, {12'h0, m_i}, tag, "i_o");
    chk({15'h0, ie_o}, {15'h0, m_ie}, tag, "ie_o");
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 16; k++) begin
      run(CMD_FETCH, {4'h0, 4'(k)}, tag);
      run(CMD_GET_HI, 8'h00, tag);
      run(CMD_GET_LO, 8'h00, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) m_r[k] = 16'h0000;
    m_p = '0; m_x = '0; m_n = '0; m_i = '0; m_t = '0; m_ie = 1'b1;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1: clear state
    chk({12'h0, p_o}, 16'h0, "R1", "p_o");
    chk({12'h0, x_o}, 16'h0, "R1", "x_o");
    chk({12'h0, n_o}, 16'h0, "R1", "n_o");
    chk({15'h0, ie_o}, 16'h1, "R1", "ie_o");
    chk({8'h0, byte_o}, 16'h0, "R1", "byte_o");

    // R3: DMA out of clear, then first fetch at 0001
    run(CMD_DMA, 8'h00, "R3");
    run(CMD_FETCH, 8'h00, "R2");
    chk(m_r[0], 16'h0002, "R3", "model R0 after dma+fetch");

    // R6: byte writes and reads over every register
    for (int k = 0; k < 16; k++) begin
      run(CMD_FETCH, {4'h7, 4'(k)}, "R2");
      run(CMD_PUT_HI, 8'(k * 16 + (15 - k)), "R6");
      run(CMD_PUT_LO, 8'(k * 37 + 5), "R6");
      run(CMD_GET_HI, 8'h00, "R6");
      run(CMD_GET_LO, 8'h00, "R6");
      run(CMD_PUT_LO, 8'(k * 11 + 1), "R6");
      run(CMD_GET_HI, 8'h00, "R6");
    end

    // R5: stepping with wrap
    for (int k = 0; k < 16; k++) begin
      run(CMD_FETCH, {4'h3, 4'(k)}, "R2");
      run(CMD_RN_INC, 8'h00, "R5");
      run(CMD_RN_DEC, 8'h00, "R5");
      run(CMD_RN_DEC, 8'h00, "R5");
      run(CMD_RX_READ, 8'h00, "R10");
    end
    run(CMD_FETCH, 8'h05, "R2");
    run(CMD_PUT_HI, 8'hFF, "R5");
    run(CMD_PUT_LO, 8'hFF, "R5");
    run(CMD_RN_INC, 8'h00, "R5");
    run(CMD_GET_HI, 8'h00, "R5");
    run(CMD_RN_DEC, 8'h00, "R5");
    run(CMD_GET_LO, 8'h00, "R5");

    // R7 and R10: selector loads, operand pointer
    for (int k = 0; k < 16; k++) begin
      run(CMD_FETCH, {4'h1, 4'(k)}, "R2");
      run(CMD_SET_X, 8'h00, "R7");
      run(CMD_RX_READ, 8'h00, "R10");
      run(CMD_RX_INC, 8'h00, "R10");
      run(CMD_RX_READ, 8'h00, "R10");
    end
    for (int k = 0; k < 16; k++) begin
      run(CMD_FETCH, {4'h2, 4'(15 - k)}, "R2");
      run(CMD_SET_P, 8'h00, "R7");
      run(CMD_FETCH, 8'h00, "R2");
      run(CMD_FETCH, 8'hA0, "R2");
    end

    // R4, R8, R9: interrupt entry, save, return, disable
    for (int a = 0; a < 16; a++) begin
      run(CMD_FETCH, {4'h0, 4'(a)}, "R2");
      run(CMD_SET_X, 8'h00, "R7");
      run(CMD_FETCH, {4'h0, 4'((a * 7 + 3) & 15)}, "R2");
      run(CMD_SET_P, 8'h00, "R7");
      run(CMD_INT, 8'h00, "R4");
      run(CMD_SAVE_T, 8'h00, "R9");
      run(CMD_RET, {4'(a), 4'((a * 7 + 3) & 15)}, "R8");
      run(CMD_RX_READ, 8'h00, "R8");
      run(CMD_INT, 8'h00, "R4");
      run(CMD_DIS, 8'(a * 29 + 60), "R8");
      run(CMD_RX_READ, 8'h00, "R8");
      run(CMD_SAVE_T, 8'h00, "R9");
    end

    // R3: DMA burst across the wrap point
    run(CMD_FETCH, 8'h00, "R2");
    run(CMD_PUT_HI, 8'hFF, "R3");
    run(CMD_PUT_LO, 8'hF6, "R3");
    for (int k = 0; k < 20; k++) run(CMD_DMA, 8'h00, "R3");

    // R11: idle and unassigned codes leave everything alone
    read_all("R11");
    run(CMD_IDLE, 8'hFF, "R11");
    for (int c = 17; c < 32; c++) run(5'(c), 8'(c * 9), "R11");
    read_all("R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule